// File: doc/BRIEF.md
# Random-Read Instruction Byte Decoder

This block watches an instruction byte stream, one byte for each cycle in which the valid strobe is high, and picks out the two-byte-opcode instruction that reads a hardware random number into a general register. It collects legacy prefixes and, in 64-bit mode, a REX prefix. It then matches the escape byte and the second opcode byte, and splits the ModRM byte into its fields. When the instruction ends, it emits a one-cycle record. The record gives the match flag, the 4-bit destination register index, the operand size and an invalid-opcode flag together with a cause mask.

Any byte sequence that is not this instruction ends in a record with the match flag low. The parser then returns to the prefix state. A front end uses the block by feeding it the byte stream, the current mode, the feature-enable bit and an external operand-size-override indication. It acts on each record as it arrives.

Top module: `rngr_dec_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `rec_valid_o` is 0.
- R2: The byte sequence 0x0F, 0xC7 followed by a ModRM byte whose bits [5:3] equal 6 and whose bits [7:6] equal 3 gives `rec_valid_o`=1 and `rec_hit_o`=1 in the cycle after the clock edge that samples the ModRM byte. `rec_reg_o[2:0]` equals ModRM bits [2:0].
- R3: Any other first non-prefix byte, a second byte other than 0xC7, or a ModRM byte whose bits [5:3] differ from 6 ends the instruction at once. It gives a record with `rec_hit_o`=0, `rec_ud_o`=0 and `rec_cause_o`=0.
- R4: The size code is 0 for 16-bit, 1 for 32-bit and 2 for 64-bit. The default is 32-bit. A 0x66 prefix or `osz_ovr_i`=1 gives 16-bit. A REX byte with bit 3 set gives 64-bit and wins over 0x66. Size 64 only occurs in 64-bit mode.
- R5: A REX byte with bit 0 set sets `rec_reg_o[3]`, so registers 8 to 15 can be reached.
- R6: A REX byte takes effect only when it is the last prefix before 0x0F. If another prefix follows it, the REX byte is discarded.
- R7: When `mode64_i`=0, bytes 0x40 to 0x4F are not prefixes. Such a byte in first position ends the instruction as not matched.
- R8: A 0xF0 prefix on a matched instruction sets `rec_ud_o` and cause bit 0, in either mode.
- R9: A 0xF2 or 0xF3 prefix on a matched instruction sets `rec_ud_o` and cause bit 1.
- R10: `feat_en_i`=0 on a matched instruction sets `rec_ud_o` and cause bit 2.
- R11: On a matched instruction, ModRM bits [7:6] other than 3 set `rec_ud_o` and cause bit 3.
- R12: After each record the parser is back in the prefix state with every prefix flag cleared.
- R13: Cycles with `byte_vld_i`=0 leave the parse state unchanged and produce no record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_vld_i | input | 1 | Byte strobe |
| byte_i | input | 8 | Instruction byte |
| mode64_i | input | 1 | 1 = 64-bit mode, 0 = legacy mode |
| feat_en_i | input | 1 | Feature enabled |
| osz_ovr_i | input | 1 | External operand-size override |
| rec_valid_o | output | 1 | Record strobe, one cycle |
| rec_hit_o | output | 1 | Instruction recognised |
| rec_reg_o | output | 4 | Destination register index |
| rec_size_o | output | 2 | Size code (0 = 16, 1 = 32, 2 = 64) |
| rec_ud_o | output | 1 | Invalid opcode |
| rec_cause_o | output | 4 | Cause mask: lock, repeat, feature off, memory form |

## Verification
The bench builds the block with its default parameters: escape byte 0x0F, second byte 0xC7 and extension value 6. These defaults bring the real encoding into reach, so every prefix mix can be driven with the byte values used in practice. The scenarios cover prefix order, REX placement, mode switching, idle gaps inside an instruction, and records that follow one another back to back. The idle-gap and back-to-back scenarios show that no state leaks from one record into the next.

// File: rtl/rngr_pkg.sv
package rngr_pkg;

  localparam int BYTE_W  = 8;
  localparam int IDX_W   = 4;
  localparam int N_CAUSE = 4;

  localparam int CB_LOCK = 0;
  localparam int CB_REP  = 1;
  localparam int CB_FEAT = 2;
  localparam int CB_MEM  = 3;

  localparam logic [BYTE_W-1:0] PFX_OSZ  = 8'h66;
  localparam logic [BYTE_W-1:0] PFX_LOCK = 8'hF0;
  localparam logic [BYTE_W-1:0] PFX_RPNZ = 8'hF2;
  localparam logic [BYTE_W-1:0] PFX_RPZ  = 8'hF3;

  typedef enum logic [1:0] {
    SZ16 = 2'd0,
    SZ32 = 2'd1,
    SZ64 = 2'd2
  } osz_e;

  typedef enum logic [1:0] {
    PS_PFX = 2'd0,
    PS_OP2 = 2'd1,
    PS_MRM = 2'd2
  } pst_e;

  // segment and address-size prefixes: accepted, no effect on this record
  function automatic logic is_pass_pfx(input logic [BYTE_W-1:0] b);
    return (b == 8'h26) || (b == 8'h2E) || (b == 8'h36) || (b == 8'h3E) ||
           (b == 8'h64) || (b == 8'h65) || (b == 8'h67);
  endfunction

  function automatic logic is_rex_code(input logic [BYTE_W-1:0] b);
    return b[7:4] == 4'h4;
  endfunction

endpackage

// File: rtl/rngr_pfx_trk.sv
module rngr_pfx_trk
  import rngr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_i,
  input  logic              clr_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              mode64_i,
  output logic              pfx_hit_o,
  output logic              p66_o,
  output logic              lock_o,
  output logic              rep_o,
  output logic              rex_vld_o,
  output logic              rex_w_o,
  output logic              rex_b_o
);

  logic rex_byte, leg_byte;
  logic p66_q, lock_q, rep_q, rex_vld_q, rex_w_q, rex_b_q;
  logic p66_n, lock_n, rep_n, rex_vld_n, rex_w_n, rex_b_n;

  assign rex_byte  = mode64_i && is_rex_code(byte_i);
  assign leg_byte  = is_pass_pfx(byte_i) || (byte_i == PFX_OSZ) ||
                     (byte_i == PFX_LOCK) || (byte_i == PFX_RPNZ) ||
                     (byte_i == PFX_RPZ);
  assign pfx_hit_o = rex_byte || leg_byte;

  always_comb begin
    p66_n     = p66_q;
    lock_n    = lock_q;
    rep_n     = rep_q;
    rex_vld_n = rex_vld_q;
    rex_w_n   = rex_w_q;
    rex_b_n   = rex_b_q;
    if (clr_i) begin
      p66_n     = 1'b0;
      lock_n    = 1'b0;
      rep_n     = 1'b0;
      rex_vld_n = 1'b0;
      rex_w_n   = 1'b0;
      rex_b_n   = 1'b0;
    end else if (take_i && pfx_hit_o) begin
      if (rex_byte) begin
        rex_vld_n = 1'b1;
        rex_w_n   = byte_i[3];
        rex_b_n   = byte_i[0];
      end else begin
        // any legacy prefix after a REX byte voids the REX byte
        rex_vld_n = 1'b0;
        rex_w_n   = 1'b0;
        rex_b_n   = 1'b0;
        if (byte_i == PFX_OSZ)  p66_n  = 1'b1;
        if (byte_i == PFX_LOCK) lock_n = 1'b1;
        if ((byte_i == PFX_RPNZ) || (byte_i == PFX_RPZ)) rep_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p66_q     <= 1'b0;
      lock_q    <= 1'b0;
      rep_q     <= 1'b0;
      rex_vld_q <= 1'b0;
      rex_w_q   <= 1'b0;
      rex_b_q   <= 1'b0;
    end else begin
      p66_q     <= p66_n;
      lock_q    <= lock_n;
      rep_q     <= rep_n;
      rex_vld_q <= rex_vld_n;
      rex_w_q   <= rex_w_n;
      rex_b_q   <= rex_b_n;
    end
  end

  assign p66_o     = p66_q;
  assign lock_o    = lock_q;
  assign rep_o     = rep_q;
  assign rex_vld_o = rex_vld_q;
  assign rex_w_o   = rex_w_q;
  assign rex_b_o   = rex_b_q;

  AST_REX_LONG_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && !mode64_i && is_rex_code(byte_i)) |=> !rex_vld_o); // R7

  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !(p66_o || lock_o || rep_o || rex_vld_o)); // R12

endmodule

// File: rtl/rngr_parse_fsm.sv
module rngr_parse_fsm
  import rngr_pkg::*;
#(
  parameter logic [BYTE_W-1:0] ESC_BYTE  = 8'h0F,
  parameter logic [BYTE_W-1:0] OPC_BYTE  = 8'hC7,
  parameter logic [2:0]        EXT_FIELD = 3'd6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_vld_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              pfx_hit_i,
  output logic              in_pfx_o,
  output logic              emit_o,
  output logic              hit_o
);

  pst_e st_q, st_n;

  always_comb begin
    st_n   = st_q;
    emit_o = 1'b0;
    hit_o  = 1'b0;
    if (byte_vld_i) begin
      unique case (st_q)
        PS_PFX: begin
          if (!pfx_hit_i) begin
            if (byte_i == ESC_BYTE) st_n = PS_OP2;
            else                    emit_o = 1'b1;
          end
        end
        PS_OP2: begin
          if (byte_i == OPC_BYTE) st_n = PS_MRM;
          else begin
            emit_o = 1'b1;
            st_n   = PS_PFX;
          end
        end
        PS_MRM: begin
          emit_o = 1'b1;
          hit_o  = (byte_i[5:3] == EXT_FIELD);
          st_n   = PS_PFX;
        end
        default: st_n = PS_PFX;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= PS_PFX;
    else        st_q <= st_n;
  end

  assign in_pfx_o = (st_q == PS_PFX);

  AST_IDLE_AFTER_EMIT: assert property (@(posedge clk) disable iff (!rst_n)
    emit_o |=> in_pfx_o); // R12

  AST_GAP_HOLDS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_vld_i |=> $stable(st_q)); // R13

  AST_GAP_NO_EMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_vld_i |-> !emit_o); // R13

endmodule

// File: rtl/rngr_rec_bld.sv
module rngr_rec_bld
  import rngr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               emit_i,
  input  logic               hit_i,
  input  logic [BYTE_W-1:0]  mrm_i,
  input  logic               p66_i,
  input  logic               lock_i,
  input  logic               rep_i,
  input  logic               rex_vld_i,
  input  logic               rex_w_i,
  input  logic               rex_b_i,
  input  logic               mode64_i,
  input  logic               feat_en_i,
  input  logic               osz_ovr_i,
  output logic               rec_valid_o,
  output logic               rec_hit_o,
  output logic [IDX_W-1:0]   rec_reg_o,
  output osz_e               rec_size_o,
  output logic               rec_ud_o,
  output logic [N_CAUSE-1:0] rec_cause_o
);

  logic               vld_q, hit_q, ud_q;
  logic [IDX_W-1:0]   reg_q, reg_n;
  osz_e               sz_q, sz_n;
  logic [N_CAUSE-1:0] cause_q, cause_n;
  logic               rex_eff;

  assign rex_eff = rex_vld_i && mode64_i;

  always_comb begin
    if (rex_eff && rex_w_i)       sz_n = SZ64;
    else if (p66_i || osz_ovr_i)  sz_n = SZ16;
    else                          sz_n = SZ32;

    reg_n = hit_i ? {rex_eff && rex_b_i, mrm_i[2:0]} : '0;

    cause_n          = '0;
    cause_n[CB_LOCK] = hit_i && lock_i;
    cause_n[CB_REP]  = hit_i && rep_i;
    cause_n[CB_FEAT] = hit_i && !feat_en_i;
    cause_n[CB_MEM]  = hit_i && (mrm_i[7:6] != 2'b11);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      hit_q   <= 1'b0;
      ud_q    <= 1'b0;
      reg_q   <= '0;
      sz_q    <= SZ32;
      cause_q <= '0;
    end else begin
      vld_q <= emit_i;
      if (emit_i) begin
        hit_q   <= hit_i;
        reg_q   <= reg_n;
        sz_q    <= sz_n;
        cause_q <= cause_n;
        ud_q    <= |cause_n;
      end
    end
  end

  assign rec_valid_o = vld_q;
  assign rec_hit_o   = hit_q;
  assign rec_reg_o   = reg_q;
  assign rec_size_o  = sz_q;
  assign rec_ud_o    = ud_q;
  assign rec_cause_o = cause_q;

  AST_MISS_IS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid_o && !rec_hit_o) |-> (rec_cause_o == '0 && !rec_ud_o)); // R3

  AST_WIDE_ONLY_LONG: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid_o && rec_size_o == SZ64) |-> $past(mode64_i)); // R4

  AST_FEAT_OFF_UD: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid_o && rec_hit_o && !$past(feat_en_i)) |-> rec_ud_o); // R10

endmodule

// File: rtl/rngr_dec_top.sv
module rngr_dec_top
  import rngr_pkg::*;
#(
  parameter logic [7:0] ESC_BYTE  = 8'h0F,
  parameter logic [7:0] OPC_BYTE  = 8'hC7,
  parameter logic [2:0] EXT_FIELD = 3'd6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       byte_vld_i,
  input  logic [7:0] byte_i,
  input  logic       mode64_i,
  input  logic       feat_en_i,
  input  logic       osz_ovr_i,
  output logic       rec_valid_o,
  output logic       rec_hit_o,
  output logic [3:0] rec_reg_o,
  output logic [1:0] rec_size_o,
  output logic       rec_ud_o,
  output logic [3:0] rec_cause_o
);

  logic in_pfx, emit, hit, pfx_hit;
  logic p66, lock, rep, rex_vld, rex_w, rex_b;
  osz_e size_e;

  rngr_parse_fsm #(
    .ESC_BYTE (ESC_BYTE),
    .OPC_BYTE (OPC_BYTE),
    .EXT_FIELD(EXT_FIELD)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .byte_vld_i(byte_vld_i),
    .byte_i    (byte_i),
    .pfx_hit_i (pfx_hit),
    .in_pfx_o  (in_pfx),
    .emit_o    (emit),
    .hit_o     (hit)
  );

  rngr_pfx_trk u_pfx (
    .clk      (clk),
    .rst_n    (rst_n),
    .take_i   (byte_vld_i && in_pfx),
    .clr_i    (emit),
    .byte_i   (byte_i),
    .mode64_i (mode64_i),
    .pfx_hit_o(pfx_hit),
    .p66_o    (p66),
    .lock_o   (lock),
    .rep_o    (rep),
    .rex_vld_o(rex_vld),
    .rex_w_o  (rex_w),
    .rex_b_o  (rex_b)
  );

  rngr_rec_bld u_rec (
    .clk        (clk),
    .rst_n      (rst_n),
    .emit_i     (emit),
    .hit_i      (hit),
    .mrm_i      (byte_i),
    .p66_i      (p66),
    .lock_i     (lock),
    .rep_i      (rep),
    .rex_vld_i  (rex_vld),
    .rex_w_i    (rex_w),
    .rex_b_i    (rex_b),
    .mode64_i   (mode64_i),
    .feat_en_i  (feat_en_i),
    .osz_ovr_i  (osz_ovr_i),
    .rec_valid_o(rec_valid_o),
    .rec_hit_o  (rec_hit_o),
    .rec_reg_o  (rec_reg_o),
    .rec_size_o (size_e),
    .rec_ud_o   (rec_ud_o),
    .rec_cause_o(rec_cause_o)
  );

  assign rec_size_o = size_e;

  AST_LOCK_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid_o && rec_hit_o && $past(lock)) |-> (rec_ud_o && rec_cause_o[CB_LOCK])); // R8

endmodule

// File: tb/rngr_dec_top_tb_top.sv
module rngr_dec_top_tb_top;

  localparam time CLK_P = 10ns;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       byte_vld_i;
  logic [7:0] byte_i;
  logic       mode64_i, feat_en_i, osz_ovr_i;
  logic       rec_valid_o, rec_hit_o, rec_ud_o;
  logic [3:0] rec_reg_o, rec_cause_o;
  logic [1:0] rec_size_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [7:0] bq [0:7];
  int bn;

  always #(CLK_P/2) clk = ~clk;

  rngr_dec_top dut_i (
    .clk(clk), .rst_n(rst_n), .byte_vld_i(byte_vld_i), .byte_i(byte_i),
    .mode64_i(mode64_i), .feat_en_i(feat_en_i), .osz_ovr_i(osz_ovr_i),
    .rec_valid_o(rec_valid_o), .rec_hit_o(rec_hit_o), .rec_reg_o(rec_reg_o),
    .rec_size_o(rec_size_o), .rec_ud_o(rec_ud_o), .rec_cause_o(rec_cause_o)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic clr_q();
    bn = 0;
  endtask

  task automatic add(input logic [7:0] b);
    bq[bn] = b;
    bn++;
  endtask

  // drives the queued bytes; returns at the negedge where the record is visible
  task automatic play(input string tag, input bit gap);
    bit early = 0;
    for (int i = 0; i < bn; i++) begin
      byte_vld_i = 1'b1;
      byte_i     = bq[i];
      @(negedge clk);
      byte_vld_i = 1'b0;
      if (i < bn - 1) begin
        if (rec_valid_o) early = 1;
        if (gap) begin
          byte_i = 8'h0F;
          @(negedge clk);
          if (rec_valid_o) early = 1;
        end
      end
    end
    chk({tag, " R13 no record before last byte"}, {7'd0, early}, 8'd0);
  endtask

  task automatic expect_rec(input string tag, input logic hit, input logic [3:0] rg,
                            input logic [1:0] sz, input logic [3:0] cause);
    chk({tag, " valid"}, {7'd0, rec_valid_o}, 8'd1);
    chk({tag, " hit"},   {7'd0, rec_hit_o},   {7'd0, hit});
    if (hit) begin
      chk({tag, " reg"},  {4'd0, rec_reg_o},  {4'd0, rg});
      chk({tag, " size"}, {6'd0, rec_size_o}, {6'd0, sz});
    end
    chk({tag, " cause"}, {4'd0, rec_cause_o}, {4'd0, cause});
    chk({tag, " ud"},    {7'd0, rec_ud_o},    {7'd0, |cause});
    @(negedge clk);
    chk({tag, " R2 single-cycle strobe"}, {7'd0, rec_valid_o}, 8'd0);
  endtask

  task automatic set_env(input logic m64, input logic fe, input logic osz);
    mode64_i = m64; feat_en_i = fe; osz_ovr_i = osz;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; byte_vld_i = 1'b0; byte_i = 8'h00;
    set_env(1'b1, 1'b1, 1'b0);
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", {7'd0, rec_valid_o}, 8'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid after reset", {7'd0, rec_valid_o}, 8'd0);
  endtask

  task automatic t_basic();
    set_env(1'b1, 1'b1, 1'b0);
    clr_q(); add(8'h0F); add(8'hC7); add(8'hF3);
    play("R2 basic", 0); expect_rec("R2 basic", 1, 4'd3, 2'd1, 4'h0);
  endtask

  task automatic t_miss();
    set_env(1'b1, 1'b1, 1'b0);
    clr_q(); add(8'h0F); add(8'hC7); add(8'hC8);
    play("R3 reg field 1", 0); expect_rec("R3 reg field 1", 0, 0, 0, 4'h0);
    clr_q(); add(8'h90);
    play("R3 first byte", 0); expect_rec("R3 first byte", 0, 0, 0, 4'h0);
    clr_q(); add(8'hF0); add(8'h0F); add(8'h05);
    play("R3 second byte", 0); expect_rec("R3 second byte", 0, 0, 0, 4'h0);
  endtask

  task automatic t_size();
    set_env(1'b1, 1'b1, 1'b0);
    clr_q(); add(8'h66); add(8'h0F); add(8'hC7); add(8'hF0);
    play("R4 66 prefix", 0); expect_rec("R4 66 prefix", 1, 4'd0, 2'd0, 4'h0);
    set_env(1'b1, 1'b1, 1'b1);
    clr_q(); add(8'h0F); add(8'hC7); add(8'hF4);
    play("R4 override pin", 0); expect_rec("R4 override pin", 1, 4'd4, 2'd0, 4'h0);
    set_env(1'b1, 1'b1, 1'b0);
    clr_q(); add(8'h48); add(8'h0F); add(8'hC7); add(8'hF1);
    play("R4 rex w", 0); expect_rec("R4 rex w", 1, 4'd1, 2'd2, 4'h0);
    clr_q(); add(8'h66); add(8'h48); add(8'h0F); add(8'hC7); add(8'hF1);
    play("R4 rex w beats 66", 0); expect_rec("R4 rex w beats 66", 1, 4'd1, 2'd2, 4'h0);
  endtask

  task automatic t_rexb();
    set_env(1'b1, 1'b1, 1'b0);
    clr_q(); add(8'h41); add(8'h0F); add(8'hC7); add(8'hF7);
    play("R5 rex b", 0); expect_rec("R5 rex b", 1, 4'd15, 2'd1, 4'h0);
    clr_q(); add(8'h49); add(8'h0F); add(8'hC7); add(8'hF1);
    play("R5 rex wb", 0); expect_rec("R5 rex wb", 1, 4'd9, 2'd2, 4'h0);
  endtask

  task automatic t_rex_order();
    set_env(1'b1, 1'b1, 1'b0);
    clr_q(); add(8'h49); add(8'h66); add(8'h0F); add(8'hC7); add(8'hF1);
    play("R6 rex not last", 0); expect_rec("R6 rex not last", 1, 4'd1, 2'd0, 4'h0);
    clr_q(); add(8'h41); add(8'h2E); add(8'h0F); add(8'hC7); add(8'hF2);
    play("R6 rex then seg", 0); expect_rec("R6 rex then seg", 1, 4'd2, 2'd1, 4'h0);
  endtask

  task automatic t_legacy();
    set_env(1'b0, 1'b1, 1'b0);
    clr_q(); add(8'h48);
    play("R7 40-4F not prefix", 0); expect_rec("R7 40-4F not prefix", 0, 0, 0, 4'h0);
    clr_q(); add(8'h0F); add(8'hC7); add(8'hF2);
    play("R7 legacy default", 0); expect_rec("R7 legacy default", 1, 4'd2, 2'd1, 4'h0);
    clr_q(); add(8'h66); add(8'h0F); add(8'hC7); add(8'hF5);
    play("R7 legacy 66", 0); expect_rec("R7 legacy 66", 1, 4'd5, 2'd0, 4'h0);
    clr_q(); add(8'hF0); add(8'h0F); add(8'hC7); add(8'hF0);
    play("R8 lock legacy", 0); expect_rec("R8 lock legacy", 1, 4'd0, 2'd1, 4'h1);
  endtask

  task automatic t_ud();
    set_env(1'b1, 1'b1, 1'b0);
    clr_q(); add(8'hF0); add(8'h0F); add(8'hC7); add(8'hF0);
    play("R8 lock", 0); expect_rec("R8 lock", 1, 4'd0, 2'd1, 4'h1);
    clr_q(); add(8'hF3); add(8'h0F); add(8'hC7); add(8'hF0);
    play("R9 f3", 0); expect_rec("R9 f3", 1, 4'd0, 2'd1, 4'h2);
    clr_q(); add(8'hF2); add(8'h0F); add(8'hC7); add(8'hF0);
    play("R9 f2", 0); expect_rec("R9 f2", 1, 4'd0, 2'd1, 4'h2);
    set_env(1'b1, 1'b0, 1'b0);
    clr_q(); add(8'h0F); add(8'hC7); add(8'hF0);
    play("R10 feature off", 0); expect_rec("R10 feature off", 1, 4'd0, 2'd1, 4'h4);
    set_env(1'b1, 1'b1, 1'b0);
    clr_q(); add(8'h0F); add(8'hC7); add(8'hB0);
    play("R11 mem form", 0); expect_rec("R11 mem form", 1, 4'd0, 2'd1, 4'h8);
  endtask

  task automatic t_clear();
    set_env(1'b1, 1'b1, 1'b0);
    clr_q(); add(8'hF0); add(8'h66); add(8'h49); add(8'h0F); add(8'hC7); add(8'hF0);
    play("R12 first", 0); expect_rec("R12 first", 1, 4'd8, 2'd2, 4'h1);
    clr_q(); add(8'h0F); add(8'hC7); add(8'hF0);
    play("R12 after clear", 0); expect_rec("R12 after clear", 1, 4'd0, 2'd1, 4'h0);
  endtask

  task automatic t_gap();
    set_env(1'b1, 1'b1, 1'b0);
    clr_q(); add(8'h41); add(8'h0F); add(8'hC7); add(8'hF6);
    play("R13 gaps", 1); expect_rec("R13 gaps", 1, 4'd14, 2'd1, 4'h0);
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_basic();
    t_miss();
    t_size();
    t_rexb();
    t_rex_order();
    t_legacy();
    t_ud();
    t_clear();
    t_gap();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule